// File: doc/BRIEF.md
# Grouped DMA Event Interrupt Register

This block is one 32-bit control/status word for a DMA bridge. Ten event sources report into it with single-cycle pulses. Two come from the USB path: transfer complete and address fault. The other eight come from two audio channels, each with a play and a record direction, and each direction signals a full-buffer and a half-buffer event. Every event has a sticky pending flag and an enable flag. A pulse latches its pending flag whether or not the event is enabled.

Three level-sensitive interrupt lines leave the block, grouped by kind of event rather than by source. Line 0 carries only the USB address fault. Line 1 carries USB transfer complete and the four audio full-buffer events. Line 2 carries the four audio half-buffer events. Each line is high while any event in its group is both pending and enabled.

Software reads the whole word to find the pending events. Writing 0 to a pending flag clears it, and writing 0 to an enable flag masks that event. The pending flags are therefore acknowledged by writing zero, not one.

Top module: `evt_irq_reg`

## Requirements
- R1: After a synchronous active-low reset the whole word reads 0 and all three interrupt lines are low.
- R2: USB transfer complete (event 0) has its pending flag at bit 0 and its enable at bit 8. USB address fault (event 1) has its pending flag at bit 1 and its enable at bit 9.
- R3: Audio event n (2..9) has its pending flag at bit n+14 and its enable at bit n+22. Events 2/3 belong to channel 0 play, 4/5 to channel 0 record, 6/7 to channel 1 play and 8/9 to channel 1 record. The even event of each pair is the full-buffer event and the odd event is the half-buffer event.
- R4: A pulse on an event input sets its pending flag at the next clock edge, whatever the state of its enable.
- R5: A write of 0 to a pending flag clears it at the clock edge. A write of 1 leaves the flag unchanged.
- R6: If a pulse and a clearing write reach the same pending flag in the same cycle, the flag ends up set.
- R7: Enable flags take the written value on every write and keep their value when no write occurs.
- R8: Bits 2..7 and 10..15 always read 0, and writes to those bits have no effect.
- R9: Interrupt line 0 is high exactly when event 1 is both pending and enabled.
- R10: Interrupt line 1 is high exactly when any of events 0, 2, 4, 6 or 8 is both pending and enabled.
- R11: Interrupt line 2 is high exactly when any of events 3, 5, 7 or 9 is both pending and enabled.
- R12: The read data and the interrupt lines reflect the register state without extra delay. A change made at a clock edge is visible on both in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the 32-bit word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| evt_pulse | input | 10 | Event pulses, bit i is event i |
| irq_o | output | 3 | Grouped level interrupt lines |

## Verification
On every cycle the assertions check four things. Each line agrees with the pending and enable bits visible on the read port. A pulse always leaves its flag set. A clearing write without a competing pulse leaves the flag clear, and a write of 1 leaves it unchanged. The unused bit positions stay zero after any write. The bench's scenarios are needed for the properties no single-cycle rule covers. These are the exact bit placement of each event as seen through writes and reads, and the pulse-versus-clear collision outcome. They also include the line behaviour when several groups are pending at once, and the fact that masking an event hides it from its line but not from the read port.

// File: rtl/evt_irq_pkg.sv
// Shared constants and position/grouping functions for the grouped event register.
// Assumes a 32-bit register word and exactly ten events on three lines.
package evt_irq_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_EVT  = 10;
    localparam int NUM_LINE = 3;
    localparam int NUM_USB  = 2;

    // Bit position of an event's pending flag in the register word.
    function automatic int stat_pos(input int n);
        return (n < NUM_USB) ? n : n + 14;
    endfunction

    // Bit position of an event's enable flag in the register word.
    function automatic int en_pos(input int n);
        return (n < NUM_USB) ? n + 8 : n + 22;
    endfunction

    // Interrupt line that carries a given event.
    function automatic int line_of(input int n);
        if (n == 1)        return 0;
        else if (n == 0)   return 1;
        else if (n % 2 == 0) return 1;
        else               return 2;
    endfunction
endpackage

// File: rtl/evt_flag_cell.sv
// One event's sticky pending flag and enable flag.
// Assumes write data bits arrive already picked from the word; a pulse beats a clear.
module evt_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_stat,
    input  logic wr_enab,
    input  logic pulse,
    output logic stat_q,
    output logic enab_q,
    output logic pend
);
    // Update pending flag: set by pulse, cleared by a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= 1'b0;
        else if (pulse)
            stat_q <= 1'b1;
        else if (wr_en && !wr_stat)
            stat_q <= 1'b0;
    end

    // Update enable flag as a plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enab_q <= 1'b0;
        else if (wr_en)
            enab_q <= wr_enab;
    end

    // Event counts toward its line only while enabled.
    always_comb pend = stat_q & enab_q;

    assert_pulse_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> stat_q);
    assert_pulse_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && wr_en && !wr_stat) |=> stat_q);
    assert_zero_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_stat && !pulse) |=> !stat_q);
    assert_one_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_stat && !pulse) |=> $stable(stat_q));
    assert_enab_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (enab_q == $past(wr_enab)));
    assert_enab_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enab_q));
endmodule

// File: rtl/evt_line_merge.sv
// ORs the enabled pending events of each group onto its interrupt line.
// Assumes the grouping given by evt_irq_pkg::line_of.
module evt_line_merge
    import evt_irq_pkg::*;
#(
    parameter int N_EVT  = NUM_EVT,
    parameter int N_LINE = NUM_LINE
) (
    input  logic [N_EVT-1:0]  pend,
    output logic [N_LINE-1:0] line
);
    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        // Gather the pending events routed to line l.
        always_comb begin
            line[l] = 1'b0;
            for (int n = 0; n < N_EVT; n++)
                if (line_of(n) == l) line[l] = line[l] | pend[n];
        end
    end
endmodule

// File: rtl/evt_irq_reg.sv
// Grouped DMA event interrupt register: ten sticky events, split enable/status
// fields in one 32-bit word, three grouped level interrupt lines.
// Assumes single-cycle event pulses and a single write strobe for the whole word.
module evt_irq_reg
    import evt_irq_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int N_EVT = NUM_EVT,
    parameter int N_IRQ = NUM_LINE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     rd_data,
    input  logic [N_EVT-1:0] evt_pulse,
    output logic [N_IRQ-1:0] irq_o
);
    logic [N_EVT-1:0] stat_q;
    logic [N_EVT-1:0] enab_q;
    logic [N_EVT-1:0] pend;

    for (genvar i = 0; i < N_EVT; i++) begin : g_cell
        localparam int SP = stat_pos(i);
        localparam int EP = en_pos(i);
        evt_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_stat (wr_data[SP]),
            .wr_enab (wr_data[EP]),
            .pulse   (evt_pulse[i]),
            .stat_q  (stat_q[i]),
            .enab_q  (enab_q[i]),
            .pend    (pend[i])
        );
    end

    // Assemble the read word from the per-event flags; unused bits stay 0.
    always_comb begin
        rd_data = '0;
        for (int n = 0; n < N_EVT; n++) begin
            rd_data[stat_pos(n)] = stat_q[n];
            rd_data[en_pos(n)]   = enab_q[n];
        end
    end

    evt_line_merge #(.N_EVT(N_EVT), .N_LINE(N_IRQ)) u_merge (
        .pend (pend),
        .line (irq_o)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));
    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data[15:10] == '0) && (rd_data[7:2] == '0)));
    assert_line0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] == (rd_data[1] & rd_data[9]));
    assert_line1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] == ((rd_data[0] & rd_data[8]) |
                     (|(rd_data[23:16] & rd_data[31:24] & 8'h55))));
    assert_line2_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[2] == (|(rd_data[23:16] & rd_data[31:24] & 8'hAA)));
endmodule

// File: tb/sim_evt_irq_reg.sv
module sim_evt_irq_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [9:0]  evt_pulse = '0;
    logic [2:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [9:0] m_st = '0;
    logic [9:0] m_en = '0;

    always #10 clk = ~clk;  // 50 MHz

    evt_irq_reg u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                    .rd_data(rd_data), .evt_pulse(evt_pulse), .irq_o(irq_o));

    function automatic int sp(input int n); return (n < 2) ? n : n + 14; endfunction
    function automatic int ep(input int n); return (n < 2) ? n + 8 : n + 22; endfunction

    function automatic logic [31:0] exp_word(input logic [9:0] s, input logic [9:0] e);
        logic [31:0] w = '0;
        for (int n = 0; n < 10; n++) begin w[sp(n)] = s[n]; w[ep(n)] = e[n]; end
        return w;
    endfunction

    function automatic logic [2:0] exp_lines(input logic [9:0] s, input logic [9:0] e);
        logic [9:0] p = s & e;
        logic [2:0] l;
        l[0] = p[1];
        l[1] = p[0] | p[2] | p[4] | p[6] | p[8];
        l[2] = p[3] | p[5] | p[7] | p[9];
        return l;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, clock once, update model, compare at next negedge.
    task automatic step(input logic [9:0] p, input logic we, input logic [31:0] d, input string tag);
        @(negedge clk);
        evt_pulse = p; wr_en = we; wr_data = d;
        @(posedge clk);
        if (we) begin
            for (int n = 0; n < 10; n++) begin
                m_en[n] = d[ep(n)];
                if (!d[sp(n)]) m_st[n] = 1'b0;
            end
        end
        m_st = m_st | p;
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0;
        chk({tag, " word R2 R3 R4 R5 R6 R7 R8 R12"}, rd_data, exp_word(m_st, m_en));
        chk({tag, " line0 R9"},  {31'd0, irq_o[0]}, {31'd0, exp_lines(m_st, m_en)[0]});
        chk({tag, " line1 R10"}, {31'd0, irq_o[1]}, {31'd0, exp_lines(m_st, m_en)[1]});
        chk({tag, " line2 R11"}, {31'd0, irq_o[2]}, {31'd0, exp_lines(m_st, m_en)[2]});
    endtask

    initial begin
        void'($urandom(32'h0000_5A17));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("reset word R1", rd_data, 32'h0);
        chk("reset lines R1", {29'd0, irq_o}, 32'h0);
        // R4: pulses land with enables off; lines stay low
        step(10'h3FF, 1'b0, 32'h0, "all pulses masked R4");
        // R8: write ones everywhere, unused bits must read 0
        step(10'h0, 1'b1, 32'hFFFF_FFFF, "write all ones R8 R7");
        // R5: clear only event 1 status (bit 1), keep others
        step(10'h0, 1'b1, 32'hFFFF_FFFD, "clear ev1 R5 R9");
        // R6: collision on event 5 (bit 19)
        step(10'h020, 1'b1, 32'hFFF7_FFFF, "collide ev5 R6");
        // R2 R3: clear all, then single events one by one
        step(10'h0, 1'b1, 32'hFF00_0300, "clear all keep enables R5");
        for (int n = 0; n < 10; n++) begin
            step(10'(1 << n), 1'b0, 32'h0, $sformatf("single ev%0d R2 R3", n));
            step(10'h0, 1'b1, 32'hFF00_0300, "ack R5");
        end
        // R7: mask everything, then pulse; status sets, lines low
        step(10'h0, 1'b1, 32'h0, "mask all R7");
        step(10'h2AA, 1'b0, 32'h0, "pulses while masked R4 R7");
        step(10'h0, 1'b1, 32'h0200_0200, "enable ev1 ev3 only R9 R11");
        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [9:0]  p = ($urandom % 4 == 0) ? 10'($urandom) : 10'h0;
            logic        we = ($urandom % 3 == 0);
            logic [31:0] d = $urandom;
            step(p, we, d, "random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired R1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule